// File: doc/BRIEF.md
# Bus Slave Register Decoder for a Sixteen-Channel Discriminator

This block is the register front end of a bus slave that configures a sixteen-channel leading-edge discriminator. Each access is presented as a one-cycle request carrying an address modifier, a 32-bit address, a direction and 16 bits of write data. The block accepts the access only when the modifier is one of the four supported data-access codes and the upper address bits match a base address set by four hexadecimal rotary switches. It then decodes the low address into the register map. Accepted accesses are acknowledged one cycle later, with read data valid alongside the acknowledge.

The block holds the configuration that the analog channels consume. That is sixteen 8-bit thresholds, two output-width codes (one per group of eight channels), an 8-bit majority code and a 16-bit channel enable mask. A write to one address is a pure trigger: it fires a one-cycle test strobe and stores nothing. Three read-only words identify the board. Address bits 15 to 9 are not decoded, so the register page repeats throughout each 64 KiB window. The full asynchronous bus handshake and block transfers are replaced by this synchronous request/acknowledge pair.

Top module: `vme_reg_decoder`

## Requirements
- R1: An access is accepted only when `am` is 0x39 or 0x3D (24-bit address) or 0x09 or 0x0D (32-bit address). With any other code there is no acknowledge, no activity pulse and no register change.
- R2: For a 24-bit code, `addr[23:16]` must equal `base_sw[7:0]`, and `addr[31:24]` is ignored. For a 32-bit code, `addr[31:16]` must equal `base_sw[15:0]`. On a mismatch there is no acknowledge and no register change.
- R3: When a `req` cycle is accepted, `ack` and `activity` are both high for exactly the following cycle. `rdata` carries the read value in that cycle and is zero in every cycle without `ack`.
- R4: Address bits 15 to 9 and bit 0 are ignored, so 0x104C and 0x284C reach the same register. When `addr[8]` is 1, the access is acknowledged, reads return zero and writes change nothing.
- R5: Channel i's threshold is written at offset 2*i (0x00 to 0x1E) from `wdata[7:0]`. It appears on `thr_flat[8*i+7:8*i]`, and every threshold resets to 1.
- R6: A threshold write of 0 stores 1.
- R7: `width_lo` is written at 0x40, `width_hi` at 0x42 and `maj_code` at 0x48, each from `wdata[7:0]`. `inhibit` is written at 0x4A from all 16 bits. All four reset to 0.
- R8: Any write to 0x4C raises `test_pulse` for one cycle, aligned with `ack`, whatever the data, and stores nothing. A read of 0x4C gives no pulse.
- R9: Reads return 0x00F5 at 0xFA and 0x0854 at 0xFC. In 0x0854, bits 15:10 hold the manufacturer code 000010 and bits 9:0 hold the type 0001010100. At 0xFE the read returns `{VERSION[3:0], SERIAL[11:0]}`, which is 0x3123 by default.
- R10: Reads of write-only or unmapped offsets are acknowledged and return zero. Writes to the identifier or unmapped offsets change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle access request |
| we | input | 1 | 1 = write, 0 = read |
| am | input | 6 | Address modifier code |
| addr | input | 32 | Byte address |
| wdata | input | 16 | Write data |
| base_sw | input | 16 | Rotary-switch base, address bits 31:16 |
| ack | output | 1 | Acknowledge, one cycle after an accepted request |
| rdata | output | 16 | Read data, valid with ack |
| activity | output | 1 | One-cycle pulse per accepted access |
| test_pulse | output | 1 | One-cycle test strobe |
| thr_flat | output | 128 | Sixteen 8-bit thresholds, channel 0 in the low byte |
| width_lo | output | 8 | Output width code, channels 0 to 7 |
| width_hi | output | 8 | Output width code, channels 8 to 15 |
| maj_code | output | 8 | Majority threshold code |
| inhibit | output | 16 | Channel enable mask |

## Verification
The qualification logic is exercised with every accepted modifier and with rejected neighbours such as 0x3E. These separate an exact code match from a partial bit test. Base matching uses 24-bit accesses with junk in the top byte and 32-bit accesses differing only in bits 31:24, which shows whether the compare width follows the modifier. Decoding is exercised with writes of distinct values to every threshold, a zero threshold, aliased offsets, the `addr[8]` page and test-trigger writes with varied data. The read-backs of each identifier word, of write-only offsets and of unmapped offsets distinguish a true map from a decoder that leaks stored values or ignores the offset.

// File: rtl/vme_reg_decoder.sv
`timescale 1ns/1ps
module vme_reg_decoder #(
  parameter int NCH = 16,
  parameter logic [3:0] VERSION = 4'h3,
  parameter logic [11:0] SERIAL = 12'h123
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [5:0]       am,
  input  logic [31:0]      addr,
  input  logic [15:0]      wdata,
  input  logic [15:0]      base_sw,
  output logic             ack,
  output logic [15:0]      rdata,
  output logic             activity,
  output logic             test_pulse,
  output logic [NCH*8-1:0] thr_flat,
  output logic [7:0]       width_lo,
  output logic [7:0]       width_hi,
  output logic [7:0]       maj_code,
  output logic [15:0]      inhibit
);
  localparam logic [6:0] W_WLO  = 7'h20;
  localparam logic [6:0] W_WHI  = 7'h21;
  localparam logic [6:0] W_MAJ  = 7'h24;
  localparam logic [6:0] W_INH  = 7'h25;
  localparam logic [6:0] W_TEST = 7'h26;
  localparam logic [6:0] W_ID0  = 7'h7D;
  localparam logic [6:0] W_ID1  = 7'h7E;
  localparam logic [6:0] W_ID2  = 7'h7F;
  localparam logic [15:0] ID_FIXED = 16'h00F5;
  localparam logic [15:0] ID_MAKER = {6'b000010, 10'b0001010100};
  localparam logic [15:0] ID_SER   = {VERSION, SERIAL};

  logic am_short, am_long, base_ok, hit, wr, rd;
  logic [6:0] woff;

  assign am_short = (am == 6'h39) || (am == 6'h3D);
  assign am_long  = (am == 6'h09) || (am == 6'h0D);
  assign base_ok  = am_long ? (addr[31:16] == base_sw) : (addr[23:16] == base_sw[7:0]);
  assign hit      = req && (am_short || am_long) && base_ok;
  assign woff     = addr[7:1];
  assign wr       = hit && we && !addr[8];
  assign rd       = hit && !we && !addr[8];

  logic [7:0] thr_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n)
        thr_q[g] <= 8'd1;
      else if (wr && woff == 7'(g))
        thr_q[g] <= (wdata[7:0] == 8'd0) ? 8'd1 : wdata[7:0];
    end
    assign thr_flat[8*g +: 8] = thr_q[g];

    a_r6_thr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      thr_q[g] != 8'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_lo <= '0;
      width_hi <= '0;
      maj_code <= '0;
      inhibit  <= '0;
    end else if (wr) begin
      if (woff == W_WLO) width_lo <= wdata[7:0];
      if (woff == W_WHI) width_hi <= wdata[7:0];
      if (woff == W_MAJ) maj_code <= wdata[7:0];
      if (woff == W_INH) inhibit  <= wdata;
    end
  end

  logic [15:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (rd) begin
      case (woff)
        W_ID0:   rd_next = ID_FIXED;
        W_ID1:   rd_next = ID_MAKER;
        W_ID2:   rd_next = ID_SER;
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack        <= 1'b0;
      activity   <= 1'b0;
      test_pulse <= 1'b0;
      rdata      <= '0;
    end else begin
      ack        <= hit;
      activity   <= hit;
      test_pulse <= wr && (woff == W_TEST);
      rdata      <= rd_next;
    end
  end

  a_r3_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req));
  a_r3_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> rdata == 16'd0);
  a_r3_activity_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    activity == ack);
  a_r1_bad_code_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !(am == 6'h39 || am == 6'h3D || am == 6'h09 || am == 6'h0D)) |=> !ack);
  a_r8_pulse_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    test_pulse |-> ack && $past(we));
  a_r5_thr_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req) |-> $stable(thr_flat));
endmodule

// File: tb/sim_vme_reg_decoder.sv
`timescale 1ns/1ps
module sim_vme_reg_decoder;
  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [5:0] am = 0;
  logic [31:0] addr = 0;
  logic [15:0] wdata = 0, base_sw = 16'h12AB;
  logic ack, activity, test_pulse;
  logic [15:0] rdata, inhibit;
  logic [127:0] thr_flat;
  logic [7:0] width_lo, width_hi, maj_code;

  int tests = 0, fails = 0;
  logic [7:0] exp_thr [16];
  logic g_ack, g_act, g_tp, g_ack2;
  logic [15:0] g_rd;

  always #2.5 clk = ~clk;

  vme_reg_decoder u0 (.clk, .rst_n, .req, .we, .am, .addr, .wdata, .base_sw,
    .ack, .rdata, .activity, .test_pulse, .thr_flat, .width_lo, .width_hi,
    .maj_code, .inhibit);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] thr_model();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = exp_thr[i];
    return v;
  endfunction

  task automatic access(input bit w, input logic [5:0] code, input logic [31:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1; we = w; am = code; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; am = 0; addr = 0; wdata = 0;
    g_ack = ack; g_act = activity; g_tp = test_pulse; g_rd = rdata;
    @(negedge clk);
    g_ack2 = ack;
  endtask

  function automatic logic [31:0] a24(input logic [15:0] off);
    return {8'h5C, 8'hAB, off};
  endfunction
  function automatic logic [31:0] a32(input logic [15:0] off);
    return {16'h12AB, off};
  endfunction

  task automatic t_reset();
    chk(ack == 0 && activity == 0 && test_pulse == 0 && rdata == 0, "R3 reset outputs idle", {ack, activity, test_pulse}, 0);
    chk(thr_flat == thr_model(), "R5 reset thresholds are 1", thr_flat, thr_model());
    chk(width_lo == 0 && width_hi == 0 && maj_code == 0 && inhibit == 0, "R7 reset control regs", {width_lo, width_hi, maj_code, inhibit}, 0);
  endtask

  task automatic t_codes();
    access(1, 6'h3E, a24(16'h0000), 16'h0077);
    chk(!g_ack && !g_act, "R1 code 0x3E rejected", g_ack, 0);
    chk(thr_flat == thr_model(), "R1 rejected write stores nothing", thr_flat, thr_model());
    access(1, 6'h08, a32(16'h0000), 16'h0077);
    chk(!g_ack && thr_flat == thr_model(), "R1 code 0x08 rejected", g_ack, 0);
    access(1, 6'h39, a24(16'h0002), 16'h0011); exp_thr[1] = 8'h11;
    chk(g_ack && g_act, "R1 code 0x39 accepted", g_ack, 1);
    access(1, 6'h3D, a24(16'h0004), 16'h0022); exp_thr[2] = 8'h22;
    chk(g_ack, "R1 code 0x3D accepted", g_ack, 1);
    access(1, 6'h09, a32(16'h0006), 16'h0033); exp_thr[3] = 8'h33;
    chk(g_ack, "R1 code 0x09 accepted", g_ack, 1);
    access(1, 6'h0D, a32(16'h0008), 16'h0044); exp_thr[4] = 8'h44;
    chk(g_ack && !g_ack2, "R3 code 0x0D accepted, one-cycle ack", {g_ack, g_ack2}, 2);
    chk(thr_flat == thr_model(), "R5 thresholds after accepted writes", thr_flat, thr_model());
  endtask

  task automatic t_base();
    access(1, 6'h39, {8'hFF, 8'hAB, 16'h000A}, 16'h0055); exp_thr[5] = 8'h55;
    chk(g_ack && thr_flat == thr_model(), "R2 24-bit ignores addr[31:24]", g_ack, 1);
    access(1, 6'h39, {8'h12, 8'hAC, 16'h000A}, 16'h0066);
    chk(!g_ack && thr_flat == thr_model(), "R2 24-bit mismatch rejected", g_ack, 0);
    access(1, 6'h09, {16'h13AB, 16'h000A}, 16'h0066);
    chk(!g_ack && thr_flat == thr_model(), "R2 32-bit compares addr[31:24]", g_ack, 0);
  endtask

  task automatic t_thresholds();
    for (int i = 0; i < 16; i++) begin
      access(1, 6'h09, a32(16'(2*i)), 16'hA500 | 16'(8'h10 + i)); exp_thr[i] = 8'(8'h10 + i);
    end
    chk(thr_flat == thr_model(), "R5 all sixteen thresholds mapped", thr_flat, thr_model());
    access(1, 6'h39, a24(16'h000E), 16'h0000); exp_thr[7] = 8'd1;
    chk(thr_flat == thr_model(), "R6 zero threshold stored as 1", thr_flat[63:56], 1);
  endtask

  task automatic t_ctrl();
    access(1, 6'h39, a24(16'h0040), 16'hFF3C);
    access(1, 6'h39, a24(16'h0042), 16'h00C3);
    access(1, 6'h39, a24(16'h0048), 16'h0038);
    access(1, 6'h39, a24(16'h004A), 16'hBEEF);
    chk(width_lo == 8'h3C && width_hi == 8'hC3, "R7 width codes", {width_lo, width_hi}, 16'h3CC3);
    chk(maj_code == 8'h38 && inhibit == 16'hBEEF, "R7 majority and inhibit", {maj_code, inhibit}, 24'h38BEEF);
  endtask

  task automatic t_test();
    access(1, 6'h39, a24(16'h004C), 16'h0000);
    chk(g_tp && g_ack && !g_ack2, "R8 test pulse with ack", g_tp, 1);
    access(1, 6'h09, a32(16'h004C), 16'hFFFF);
    chk(g_tp, "R8 test pulse independent of data", g_tp, 1);
    access(0, 6'h09, a32(16'h004C), 16'h0000);
    chk(!g_tp && g_ack && g_rd == 0, "R8 read of trigger gives no pulse", g_tp, 0);
  endtask

  task automatic t_alias();
    access(1, 6'h39, a24(16'h104C), 16'h0001);
    chk(g_tp, "R4 alias 0x104C reaches trigger", g_tp, 1);
    access(1, 6'h39, a24(16'h284C), 16'h0001);
    chk(g_tp, "R4 alias 0x284C reaches trigger", g_tp, 1);
    access(1, 6'h39, a24(16'h7E03), 16'h0099); exp_thr[1] = 8'h99;
    chk(thr_flat == thr_model(), "R4 bits 15:9 and 0 ignored on threshold", thr_flat, thr_model());
    access(1, 6'h39, a24(16'h0140), 16'h0077);
    chk(g_ack && width_lo == 8'h3C, "R4 addr[8] page writes nothing", width_lo, 8'h3C);
    access(0, 6'h39, a24(16'h01FC), 16'h0000);
    chk(g_ack && g_rd == 0, "R4 addr[8] page reads zero", g_rd, 0);
  endtask

  task automatic t_ids();
    access(0, 6'h39, a24(16'h00FA), 0);
    chk(g_ack && g_rd == 16'h00F5, "R9 fixed code word", g_rd, 16'h00F5);
    access(0, 6'h0D, a32(16'h00FC), 0);
    chk(g_rd == 16'h0854, "R9 maker/type word", g_rd, 16'h0854);
    access(0, 6'h39, a24(16'h34FE), 0);
    chk(g_rd == 16'h3123 && !g_ack2, "R9 version/serial word", g_rd, 16'h3123);
  endtask

  task automatic t_unmapped();
    access(0, 6'h39, a24(16'h004A), 0);
    chk(g_ack && g_act && g_rd == 0, "R10 read of write-only inhibit is zero", g_rd, 0);
    access(0, 6'h39, a24(16'h0002), 0);
    chk(g_ack && g_rd == 0, "R10 read of threshold is zero", g_rd, 0);
    access(0, 6'h39, a24(16'h0080), 0);
    chk(g_ack && g_rd == 0, "R10 unmapped read is zero", g_rd, 0);
    access(1, 6'h39, a24(16'h00FC), 16'h1234);
    access(1, 6'h39, a24(16'h0060), 16'h1234);
    chk(thr_flat == thr_model() && inhibit == 16'hBEEF && maj_code == 8'h38 && width_hi == 8'hC3,
        "R10 writes to id/unmapped change nothing", inhibit, 16'hBEEF);
    access(0, 6'h39, a24(16'h00FC), 0);
    chk(g_rd == 16'h0854, "R10 id word unchanged by write", g_rd, 16'h0854);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_thr[i] = 8'd1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_codes();
    t_base();
    t_thresholds();
    t_ctrl();
    t_test();
    t_alias();
    t_ids();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule